// File: doc/BRIEF.md
# Divider Quotient Rounding Stage

This block sits behind an integer divider core whose quotient is truncated toward zero. It takes the core's truncated quotient, its remainder, the divisor and the sign of the original dividend, and turns the quotient into the nearest integer. When the remainder is exactly half the divisor, a fixed tie rule applies. Signed or unsigned operation is chosen at build time. A divide-by-zero flag from the core travels alongside the quotient, so the flag and the quotient it qualifies always leave the block together.

The work is split into two logic steps. The first step compares twice the remainder magnitude with the divisor magnitude and decides whether the quotient magnitude must grow. The second step applies +1 or -1 to the quotient. A register after either step can be switched on or off by parameter. One clock enable, shared with the core, freezes every register so the whole pipeline can stall as a unit. The block has no remainder output.

Top module: `qround_unit`

## Requirements
- R1: When 2·|remainder| is less than |divisor|, the output quotient equals the input quotient (7/3 gives 2, 100/201 unsigned gives 0).
- R2: When 2·|remainder| is greater than |divisor|, the quotient magnitude grows by one. The direction is toward negative when exactly one operand is negative in signed mode and positive otherwise (8/3 gives 3, -8/3 gives -3, -5/6 gives -1).
- R3: In unsigned mode an exact half always rounds up (1/2 gives 1, 7/2 gives 4, 255/2 gives 128), and the output never differs from the input quotient by anything other than 0 or +1.
- R4: In signed mode with a dividend of zero or above, an exact half grows the magnitude (3/6 gives 1, 3/-6 gives -1, 7/2 gives 4).
- R5: In signed mode with a negative dividend, an exact half keeps the magnitude (-3/6 gives 0, -3/-6 gives 0, -7/2 gives -3).
- R6: The divide-by-zero flag leaves the block unchanged and in the same cycle as the quotient computed from the same inputs.
- R7: The latency in enabled cycles equals the number of step registers switched on (REG_S1 + REG_S2). While the enable is low, no register changes and the outputs hold.
- R8: While reset is asserted, the quotient output and the divide-by-zero output are zero.
- R9: The rounded result wraps modulo 2^QW with no overflow detection (signed 8-bit -128/-1 gives -128).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Clock enable shared with the divider core; low stalls all registers |
| q_in | input | QW | Truncated quotient from the core |
| rem_in | input | DW | Remainder from the core, carrying the dividend's sign in signed mode |
| dvr_in | input | DW | Divisor |
| dvd_neg | input | 1 | Sign of the original dividend (1 = negative); used only in signed mode |
| dbz_in | input | 1 | Divide-by-zero flag from the core |
| q_out | output | QW | Rounded quotient |
| dbz_out | output | 1 | Divide-by-zero flag aligned with q_out |

## Verification
The bench builds two copies side by side. The first is signed, with 8-bit quotient and divisor and both step registers on, so the latency is two. This reaches the sign-dependent tie rules, the most negative divisor and the -128/-1 wrap. The second is unsigned with only the second step registered, so the latency is one. It covers the always-up tie rule and large unsigned remainders near the divisor. It also tests the single-register case, where the first step feeds the output register without a register in between. Both copies share stall periods, so held outputs and the enable-gated latency count are checked for both register layouts at once.

// File: rtl/qrnd_pkg.sv
package qrnd_pkg;

  // Adjustment chosen by the first step, applied by the second
  typedef enum logic [1:0] {
    ADJ_KEEP = 2'd0,
    ADJ_INC  = 2'd1,
    ADJ_DEC  = 2'd2
  } adj_e;

  localparam int ADJ_W = 2;

endpackage

// File: rtl/qrnd_half_cmp.sv
module qrnd_half_cmp
  import qrnd_pkg::*;
#(
  parameter int DW     = 8,
  parameter bit SIGNED = 1'b1
) (
  input  logic [DW-1:0] rem_in,
  input  logic [DW-1:0] dvr_in,
  input  logic          dvd_neg,
  output adj_e          adj
);

  localparam int MW = DW + 1;   // magnitude width, holds |most negative|
  localparam int CW = DW + 2;   // comparison width, holds 2*magnitude

  logic          rem_neg;
  logic          dvr_neg;
  logic [MW-1:0] rem_ext;
  logic [MW-1:0] dvr_ext;
  logic [MW-1:0] rem_mag;
  logic [MW-1:0] dvr_mag;
  logic [CW-1:0] rem_twice;
  logic [CW-1:0] dvr_cmp;
  logic          above;
  logic          tie;
  logic          tie_up;
  logic          bump;
  logic          q_neg;

  always_comb begin
    rem_neg = SIGNED && rem_in[DW-1];
    dvr_neg = SIGNED && dvr_in[DW-1];
    rem_ext = {rem_neg, rem_in};
    dvr_ext = {dvr_neg, dvr_in};
    rem_mag = rem_neg ? (~rem_ext + MW'(1)) : rem_ext;
    dvr_mag = dvr_neg ? (~dvr_ext + MW'(1)) : dvr_ext;
    rem_twice = {rem_mag, 1'b0};
    dvr_cmp   = {1'b0, dvr_mag};
    above  = rem_twice > dvr_cmp;
    tie    = rem_twice == dvr_cmp;
    // exact half: unsigned always up, signed up only for a non-negative dividend
    tie_up = !SIGNED || !dvd_neg;
    bump   = above || (tie && tie_up);
    q_neg  = SIGNED && (dvd_neg ^ dvr_neg);
    if (!bump)      adj = ADJ_KEEP;
    else if (q_neg) adj = ADJ_DEC;
    else            adj = ADJ_INC;
  end

endmodule

// File: rtl/qrnd_adjust.sv
module qrnd_adjust
  import qrnd_pkg::*;
#(
  parameter int QW = 8
) (
  input  logic [QW-1:0] q_in,
  input  adj_e          adj,
  output logic [QW-1:0] q_out
);

  always_comb begin
    unique case (adj)
      ADJ_INC: q_out = q_in + QW'(1);
      ADJ_DEC: q_out = q_in - QW'(1);
      default: q_out = q_in;
    endcase
  end

endmodule

// File: rtl/qrnd_stage_reg.sv
module qrnd_stage_reg #(
  parameter int W       = 8,
  parameter bit PRESENT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (PRESENT) begin : g_reg
      logic [W-1:0] q_r;
      logic [W-1:0] q_nxt;

      always_comb begin
        q_nxt = en ? d : q_r;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= q_nxt;
      end

      assign q = q_r;
    end else begin : g_wire
      logic unused_ok;
      assign unused_ok = &{1'b0, clk, rst_n, en};
      assign q = d;
    end
  endgenerate

endmodule

// File: rtl/qround_unit.sv
module qround_unit
  import qrnd_pkg::*;
#(
  parameter int QW     = 8,
  parameter int DW     = 8,
  parameter bit SIGNED = 1'b1,
  parameter bit REG_S1 = 1'b1,
  parameter bit REG_S2 = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [QW-1:0] q_in,
  input  logic [DW-1:0] rem_in,
  input  logic [DW-1:0] dvr_in,
  input  logic          dvd_neg,
  input  logic          dbz_in,
  output logic [QW-1:0] q_out,
  output logic          dbz_out
);

  localparam int S1W = QW + ADJ_W + 1;
  localparam int S2W = QW + 1;

  adj_e           adj_c;
  logic [S1W-1:0] s1_d;
  logic [S1W-1:0] s1_q;
  adj_e           s1_adj;
  logic [QW-1:0]  s1_quo;
  logic           s1_dbz;
  logic [QW-1:0]  s2_quo;
  logic [S2W-1:0] s2_d;
  logic [S2W-1:0] s2_q;

  // step 1: half comparison and direction
  qrnd_half_cmp #(.DW(DW), .SIGNED(SIGNED)) u_cmp (
    .rem_in  (rem_in),
    .dvr_in  (dvr_in),
    .dvd_neg (dvd_neg),
    .adj     (adj_c)
  );

  assign s1_d = {dbz_in, adj_c, q_in};

  qrnd_stage_reg #(.W(S1W), .PRESENT(REG_S1)) u_reg1 (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .d     (s1_d),
    .q     (s1_q)
  );

  assign s1_quo = s1_q[QW-1:0];
  assign s1_adj = adj_e'(s1_q[QW +: ADJ_W]);
  assign s1_dbz = s1_q[S1W-1];

  // step 2: apply +1 / -1
  qrnd_adjust #(.QW(QW)) u_adj (
    .q_in  (s1_quo),
    .adj   (s1_adj),
    .q_out (s2_quo)
  );

  assign s2_d = {s1_dbz, s2_quo};

  qrnd_stage_reg #(.W(S2W), .PRESENT(REG_S2)) u_reg2 (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .d     (s2_d),
    .q     (s2_q)
  );

  assign q_out   = s2_q[QW-1:0];
  assign dbz_out = s2_q[QW];

endmodule

// File: rtl/qround_unit_chk.sv
module qround_unit_chk #(
  parameter int QW     = 8,
  parameter int DW     = 8,
  parameter bit SIGNED = 1'b1,
  parameter bit REG_S1 = 1'b1,
  parameter bit REG_S2 = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic [QW-1:0] q_in,
  input logic [DW-1:0] rem_in,
  input logic [DW-1:0] dvr_in,
  input logic          dvd_neg,
  input logic          dbz_in,
  input logic [QW-1:0] q_out,
  input logic          dbz_out
);

  localparam int LAT = int'(REG_S1) + int'(REG_S2);

  logic [1:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          warm <= 2'd0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  logic unused_ok;
  assign unused_ok = &{1'b0, rem_in, dvr_in, dvd_neg};

  generate
    if (LAT >= 1) begin : g_seq
      // R8: outputs cleared during reset
      assert_reset_zero_R8: assert property (@(posedge clk)
        !rst_n |-> (q_out == '0 && !dbz_out));

      // R7: a stalled cycle changes nothing at the outputs
      assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(q_out) && $stable(dbz_out)));
    end

    if (LAT == 2) begin : g_lat2
      assert_dbz_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (warm >= 2'd2 && $past(en, 1) && $past(en, 2))
          |-> dbz_out == $past(dbz_in, 2));

      assert_step_unit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (warm >= 2'd2 && $past(en, 1) && $past(en, 2))
          |-> (QW'(q_out - $past(q_in, 2)) == '0 ||
               QW'(q_out - $past(q_in, 2)) == QW'(1) ||
               QW'(q_out - $past(q_in, 2)) == '1));

      if (!SIGNED) begin : g_uns
        assert_unsigned_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
          (warm >= 2'd2 && $past(en, 1) && $past(en, 2))
            |-> (QW'(q_out - $past(q_in, 2)) == '0 ||
                 QW'(q_out - $past(q_in, 2)) == QW'(1)));
      end
    end else if (LAT == 1) begin : g_lat1
      assert_dbz_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (warm >= 2'd1 && $past(en)) |-> dbz_out == $past(dbz_in));

      assert_step_unit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (warm >= 2'd1 && $past(en))
          |-> (QW'(q_out - $past(q_in)) == '0 ||
               QW'(q_out - $past(q_in)) == QW'(1) ||
               QW'(q_out - $past(q_in)) == '1));

      if (!SIGNED) begin : g_uns
        assert_unsigned_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
          (warm >= 2'd1 && $past(en))
            |-> (QW'(q_out - $past(q_in)) == '0 ||
                 QW'(q_out - $past(q_in)) == QW'(1)));
      end
    end
  endgenerate

endmodule

bind qround_unit qround_unit_chk #(
  .QW(QW), .DW(DW), .SIGNED(SIGNED), .REG_S1(REG_S1), .REG_S2(REG_S2)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en      (en),
  .q_in    (q_in),
  .rem_in  (rem_in),
  .dvr_in  (dvr_in),
  .dvd_neg (dvd_neg),
  .dbz_in  (dbz_in),
  .q_out   (q_out),
  .dbz_out (dbz_out)
);

// File: tb/sim_qround_unit.sv
module sim_qround_unit;

  typedef struct {
    logic [7:0] q;
    bit         dz;
    bit         chkq;
    string      tag;
  } item_t;

  logic       clk;
  logic       rst_n;
  logic       en;
  logic [7:0] s_q, s_r, s_b;
  logic       s_neg, s_dz;
  logic [7:0] u_q, u_r, u_b;
  logic       u_neg, u_dz;
  logic [7:0] s_out, u_out;
  logic       s_dzo, u_dzo;

  int checks = 0;
  int errors = 0;
  int ns = 0;
  int nu = 0;
  bit last_en = 1'b0;
  bit done = 1'b0;
  item_t exp_s[$];
  item_t exp_u[$];

  // signed, both steps registered: latency 2
  qround_unit #(.QW(8), .DW(8), .SIGNED(1'b1), .REG_S1(1'b1), .REG_S2(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en),
    .q_in(s_q), .rem_in(s_r), .dvr_in(s_b), .dvd_neg(s_neg), .dbz_in(s_dz),
    .q_out(s_out), .dbz_out(s_dzo)
  );

  // unsigned, second step registered only: latency 1
  qround_unit #(.QW(8), .DW(8), .SIGNED(1'b0), .REG_S1(1'b0), .REG_S2(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .en(en),
    .q_in(u_q), .rem_in(u_r), .dvr_in(u_b), .dvd_neg(u_neg), .dbz_in(u_dz),
    .q_out(u_out), .dbz_out(u_dzo)
  );

  initial begin
    clk = 1'b0;
    forever #2 clk = ~clk;
  end

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic logic [7:0] ref_signed(input int a, input int b);
    int n, d, m, f2;
    n = (a < 0) ? -a : a;
    d = (b < 0) ? -b : b;
    m = n / d;
    f2 = 2 * (n % d);
    if (f2 > d || (f2 == d && a >= 0)) m++;
    return 8'(((a < 0) != (b < 0)) ? -m : m);
  endfunction

  function automatic logic [7:0] ref_unsigned(input int a, input int b);
    int m;
    m = a / b;
    if (2 * (a % b) >= b) m++;
    return 8'(m);
  endfunction

  // driver: one enabled cycle per call, expected items pushed into the scoreboard
  task automatic send(input int sa, input int sb, input int ua, input int ub, input string tag);
    item_t is, iu;
    @(negedge clk);
    en = 1'b1;
    s_neg = (sa < 0);
    if (sb == 0) begin
      s_q = 8'hFF; s_r = 8'(sa); s_b = 8'd0; s_dz = 1'b1;
      is = '{q: 8'd0, dz: 1'b1, chkq: 1'b0, tag: tag};
    end else begin
      s_q = 8'(sa / sb); s_r = 8'(sa % sb); s_b = 8'(sb); s_dz = 1'b0;
      is = '{q: ref_signed(sa, sb), dz: 1'b0, chkq: 1'b1, tag: tag};
    end
    u_neg = ua[7];
    if (ub == 0) begin
      u_q = 8'hFF; u_r = 8'(ua); u_b = 8'd0; u_dz = 1'b1;
      iu = '{q: 8'd0, dz: 1'b1, chkq: 1'b0, tag: tag};
    end else begin
      u_q = 8'(ua / ub); u_r = 8'(ua % ub); u_b = 8'(ub); u_dz = 1'b0;
      iu = '{q: ref_unsigned(ua, ub), dz: 1'b0, chkq: 1'b1, tag: tag};
    end
    exp_s.push_back(is);
    exp_u.push_back(iu);
  endtask

  // R7: stall with changing inputs; outputs must hold
  task automatic stall(input int cycles);
    logic [7:0] hs, hu;
    logic hsd, hud;
    @(negedge clk);
    hs = s_out; hu = u_out; hsd = s_dzo; hud = u_dzo;
    en = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      s_q = 8'(i * 37); s_r = 8'(i * 5 + 1); s_b = 8'(i + 3); s_dz = i[0];
      u_q = 8'(i * 11); u_r = 8'(i * 7 + 2); u_b = 8'(i + 4); u_dz = i[1];
      @(negedge clk);
      check(s_out == hs && s_dzo == hsd, "R7 signed hold", int'(s_out), int'(hs));
      check(u_out == hu && u_dzo == hud, "R7 unsigned hold", int'(u_out), int'(hu));
    end
  endtask

  always @(posedge clk) last_en <= rst_n && en;

  // monitor: compare outputs with the scoreboard after each enabled edge
  always @(negedge clk) begin
    item_t it;
    if (last_en) begin
      ns++;
      nu++;
      if (ns >= 2 && exp_s.size() > 0) begin
        it = exp_s.pop_front();
        check(s_dzo == it.dz, {"R6 signed flag ", it.tag}, int'(s_dzo), int'(it.dz));
        if (it.chkq)
          check(s_out == it.q, {"signed ", it.tag}, int'($signed(s_out)), int'($signed(it.q)));
      end
      if (nu >= 1 && exp_u.size() > 0) begin
        it = exp_u.pop_front();
        check(u_dzo == it.dz, {"R6 unsigned flag ", it.tag}, int'(u_dzo), int'(it.dz));
        if (it.chkq)
          check(u_out == it.q, {"unsigned ", it.tag}, int'(u_out), int'(it.q));
      end
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; en = 1'b0;
    s_q = '0; s_r = '0; s_b = 8'd1; s_neg = 1'b0; s_dz = 1'b0;
    u_q = '0; u_r = '0; u_b = 8'd1; u_neg = 1'b0; u_dz = 1'b0;
    repeat (3) @(negedge clk);
    check(s_out == 8'd0 && s_dzo == 1'b0, "R8 signed reset", int'(s_out), 0);
    check(u_out == 8'd0 && u_dzo == 1'b0, "R8 unsigned reset", int'(u_out), 0);
    rst_n = 1'b1;

    send(   7,    3,  100, 201, "R1 below half");
    send(   8,    3,  200, 201, "R2 above half");
    send(  -8,    3,  255,   2, "R2 neg quotient / R3 tie");
    send(   8,   -3,    1,   2, "R2 neg divisor / R3 tie");
    send(  -8,   -3,    7,   2, "R2 both neg / R3 tie");
    send(  -5,    6,  255, 255, "R2 zero quotient");
    send(   3,    6,    3,   6, "R4 tie pos / R3");
    send(   3,   -6,    0,   5, "R4 tie neg divisor");
    send(   7,    2,   10,   4, "R4 tie pos / R3");
    send(  -3,    6,   11,   4, "R5 tie neg");
    send(  -3,   -6,    9,   4, "R5 tie both neg");
    send(  -7,    2,   13,   4, "R5 tie neg");
    send(-128,   -1,  255,   1, "R9 wrap");
    send( 127, -128,  128, 255, "R2 most negative divisor");
    send(-128,    3,  254, 255, "R2 most negative dividend");
    send(  25,    0,   40,   0, "R6 divide by zero");
    send(  10,    4,   50,  20, "R4 after zero");

    stall(4);
    send(  -9,    2,   99,  10, "R7 resume R5");
    send(   9,    2,   95,  10, "R7 resume R4");
    send(  11,   -4,   96,  10, "R7 resume R2");
    stall(3);

    for (int a = -24; a <= 24; a += 3) begin
      for (int b = -7; b <= 7; b += 2) begin
        send(a, b, (a + 24) * 5, (b + 8) * 3, "R1 R2 sweep");
      end
    end

    send(1, 1, 1, 1, "flush");
    send(1, 1, 1, 1, "flush");
    @(negedge clk);
    en = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    finish_run();
  end

endmodule